// File: doc/BRIEF.md
# Multi-Mode Operand Address Unit

This unit carries out one accumulate instruction of the form `dst = dst + operand`. The operand can come from a register, from a sign-extended constant, or from data memory through one of several address calculations. The unit holds a register file of eight 32-bit registers. It drives a single-port data memory whose read data returns one cycle after the request. It issues one read, or two chained reads, as the addressing mode needs. It then writes the sum back to the destination register. In the post-increment and pre-decrement modes it also updates the base register by the element size of 4 bytes.

A host pulses `start_i` while the unit is idle, with the mode code, three register numbers and a 16-bit constant. The unit passes through address, read, execute and writeback states. In the cycle after the writeback it raises `done_o` for one cycle, and `regs_o` already shows the new register values. All registers reset to zero. The host therefore loads values with immediate-mode instructions. All arithmetic wraps modulo 2^32.

Top module: `opaddr_unit`

## Requirements
- R1: After reset all registers read zero, `done_o` is low and no memory read is issued while the unit is idle.
- R2: Mode 0 adds register `rs` to `rd`. Mode 1 adds the 16-bit constant, sign-extended to 32 bits. Neither mode issues a memory read.
- R3: Mode 2 reads at `R[rs] + const`. Mode 3 reads at `R[rs]`. Mode 5 reads at the sign-extended constant. Each of these issues exactly one read and adds the returned word to `rd`.
- R4: Mode 4 reads at `R[rs] + R[rx]`. Mode 9 reads at `const + R[rs] + (R[rx] << 2)`. Each issues exactly one read.
- R5: Mode 6 reads at `R[rs]`. It then issues a second read at the returned word, and the second word is the operand. That makes exactly two reads.
- R6: Mode 7 reads at the old `R[rs]`, then sets `R[rs]` to the old value plus 4.
- R7: Mode 8 first sets `R[rs]` to the old value minus 4, then reads at that new value.
- R8: In modes 7 and 8, when `rd` equals `rs`, the base-register update is written last and is the value that remains.
- R9: `done_o` is high for exactly one cycle per accepted instruction. `regs_o` changes only in a cycle where `done_o` is high.
- R10: A `start_i` pulse while the unit is busy is ignored. It produces no extra `done_o` and no register change.
- R11: Mode codes 10 to 15 issue no read and change no register, but still complete with a `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| mode_i | input | 4 | Addressing mode code |
| rd_i | input | 3 | Destination register number |
| rs_i | input | 3 | Base or source register number |
| rx_i | input | 3 | Index register number |
| imm_i | input | 16 | Displacement, constant or direct address |
| mem_re_o | output | 1 | Data memory read request |
| mem_addr_o | output | 32 | Data memory byte address |
| mem_rdata_i | input | 32 | Read data, valid the cycle after the request |
| done_o | output | 1 | One-cycle completion pulse |
| regs_o | output | 256 | Register file contents, register n at bits n*32 and up |

## Verification
The hardest cases to reach are the ones where one register has two roles at once. Examples are a post-increment or pre-decrement whose destination is also the base, and a scaled or indexed address where the base and the index are the same register. Reaching them needs nonzero register values, because reset leaves every register at zero. The stimulus therefore loads registers with immediate instructions first and then runs directed cases that reuse the same register number across fields. After that it runs a long constrained-random stream. In that stream the register numbers come from a 3-bit space, so such collisions happen often, and start strobes are injected while the unit is busy.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
  localparam logic [3:0] AM_REG    = 4'd0;
  localparam logic [3:0] AM_IMM    = 4'd1;
  localparam logic [3:0] AM_DISP   = 4'd2;
  localparam logic [3:0] AM_RIND   = 4'd3;
  localparam logic [3:0] AM_INDEX  = 4'd4;
  localparam logic [3:0] AM_DIRECT = 4'd5;
  localparam logic [3:0] AM_MIND   = 4'd6;
  localparam logic [3:0] AM_AINC   = 4'd7;
  localparam logic [3:0] AM_ADEC   = 4'd8;
  localparam logic [3:0] AM_SCALED = 4'd9;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_WAIT1, S_ADDR2, S_WAIT2, S_EXEC, S_WB
  } state_e;
endpackage

// File: rtl/opaddr_agen.sv
module opaddr_agen
  import opaddr_pkg::*;
#(
  parameter int DW  = 32,
  parameter int ESH = 2
) (
  input  logic [3:0]    mode_i,
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] index_i,
  input  logic [DW-1:0] imm_i,
  output logic [DW-1:0] addr_o,
  output logic          mem_o,
  output logic          chain_o,
  output logic          bupd_o,
  output logic [DW-1:0] base_new_o
);
  localparam logic [DW-1:0] ESTEP = {{(DW-1){1'b0}}, 1'b1} << ESH;

  always_comb begin
    addr_o     = '0;
    mem_o      = 1'b0;
    chain_o    = 1'b0;
    bupd_o     = 1'b0;
    base_new_o = base_i;
    case (mode_i)
      AM_DISP:   begin addr_o = base_i + imm_i;   mem_o = 1'b1; end
      AM_RIND:   begin addr_o = base_i;           mem_o = 1'b1; end
      AM_INDEX:  begin addr_o = base_i + index_i; mem_o = 1'b1; end
      AM_DIRECT: begin addr_o = imm_i;            mem_o = 1'b1; end
      AM_MIND:   begin addr_o = base_i; mem_o = 1'b1; chain_o = 1'b1; end
      AM_AINC: begin
        addr_o     = base_i;
        mem_o      = 1'b1;
        bupd_o     = 1'b1;
        base_new_o = base_i + ESTEP;
      end
      AM_ADEC: begin
        addr_o     = base_i - ESTEP;
        mem_o      = 1'b1;
        bupd_o     = 1'b1;
        base_new_o = base_i - ESTEP;
      end
      AM_SCALED: begin
        addr_o = imm_i + base_i + (index_i << ESH);
        mem_o  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/opaddr_regfile.sv
module opaddr_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wa_en_i,
  input  logic [RW-1:0]             wa_sel_i,
  input  logic [DW-1:0]             wa_data_i,
  input  logic                      wb_en_i,
  input  logic [RW-1:0]             wb_sel_i,
  input  logic [DW-1:0]             wb_data_i,
  output logic [NREG-1:0][DW-1:0]   regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    // port b (base update) has priority over port a
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs_o[g] <= '0;
      else if (wb_en_i && wb_sel_i == RW'(g))   regs_o[g] <= wb_data_i;
      else if (wa_en_i && wa_sel_i == RW'(g))   regs_o[g] <= wa_data_i;
    end
  end
endmodule

// File: rtl/opaddr_unit.sv
module opaddr_unit
  import opaddr_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 8,
  parameter int IMMW = 16,
  parameter int ESH  = 2,
  localparam int RW  = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [3:0]         mode_i,
  input  logic [RW-1:0]      rd_i,
  input  logic [RW-1:0]      rs_i,
  input  logic [RW-1:0]      rx_i,
  input  logic [IMMW-1:0]    imm_i,
  output logic               mem_re_o,
  output logic [DW-1:0]      mem_addr_o,
  input  logic [DW-1:0]      mem_rdata_i,
  output logic               done_o,
  output logic [NREG*DW-1:0] regs_o
);
  state_e                  state_q;
  logic [3:0]              mode_q;
  logic [RW-1:0]           rd_q, rs_q, rx_q;
  logic [IMMW-1:0]         imm_q;
  logic [DW-1:0]           op_q, sum_q;
  logic                    done_q;
  logic                    busy;

  logic [NREG-1:0][DW-1:0] regs_w;
  logic [DW-1:0]           imm_ext, base_val, index_val, dst_val, operand;
  logic [DW-1:0]           ag_addr, ag_base_new;
  logic                    ag_mem, ag_chain, ag_bupd;
  logic                    mode_ok;

  assign busy      = (state_q != S_IDLE);
  assign imm_ext   = {{(DW-IMMW){imm_q[IMMW-1]}}, imm_q};
  assign base_val  = regs_w[rs_q];
  assign index_val = regs_w[rx_q];
  assign dst_val   = regs_w[rd_q];
  assign mode_ok   = (mode_q <= AM_SCALED);

  opaddr_agen #(.DW(DW), .ESH(ESH)) i_agen (
    .mode_i    (mode_q),
    .base_i    (base_val),
    .index_i   (index_val),
    .imm_i     (imm_ext),
    .addr_o    (ag_addr),
    .mem_o     (ag_mem),
    .chain_o   (ag_chain),
    .bupd_o    (ag_bupd),
    .base_new_o(ag_base_new)
  );

  always_comb begin
    case (mode_q)
      AM_REG:  operand = base_val;
      AM_IMM:  operand = imm_ext;
      default: operand = op_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      mode_q  <= '0;
      rd_q    <= '0;
      rs_q    <= '0;
      rx_q    <= '0;
      imm_q   <= '0;
      op_q    <= '0;
      sum_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == S_WB);
      case (state_q)
        S_IDLE: if (start_i) begin
          mode_q  <= mode_i;
          rd_q    <= rd_i;
          rs_q    <= rs_i;
          rx_q    <= rx_i;
          imm_q   <= imm_i;
          state_q <= S_ADDR;
        end
        S_ADDR:  state_q <= ag_mem ? S_WAIT1 : S_EXEC;
        S_WAIT1: begin
          op_q    <= mem_rdata_i;
          state_q <= ag_chain ? S_ADDR2 : S_EXEC;
        end
        S_ADDR2: state_q <= S_WAIT2;
        S_WAIT2: begin
          op_q    <= mem_rdata_i;
          state_q <= S_EXEC;
        end
        S_EXEC: begin
          sum_q   <= dst_val + operand;
          state_q <= S_WB;
        end
        S_WB:    state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mem_re_o   = (state_q == S_ADDR && ag_mem) || (state_q == S_ADDR2);
  assign mem_addr_o = (state_q == S_ADDR2) ? op_q : ag_addr;
  assign done_o     = done_q;

  opaddr_regfile #(.DW(DW), .NREG(NREG)) i_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wa_en_i  (state_q == S_WB && mode_ok),
    .wa_sel_i (rd_q),
    .wa_data_i(sum_q),
    .wb_en_i  (state_q == S_WB && ag_bupd),
    .wb_sel_i (rs_q),
    .wb_data_i(ag_base_new),
    .regs_o   (regs_w)
  );

  assign regs_o = regs_w;
endmodule

// File: rtl/opaddr_chk.sv
module opaddr_chk #(
  parameter int DW   = 32,
  parameter int NREG = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               done_o,
  input logic               mem_re_o,
  input logic               busy_i,
  input logic [3:0]         mode_i,
  input logic [NREG*DW-1:0] regs_i
);
  logic [2:0] rd_cnt;
  logic [2:0] rd_exp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 rd_cnt <= '0;
    else if (start_i && !busy_i) rd_cnt <= '0;
    else if (mem_re_o)           rd_cnt <= rd_cnt + 3'd1;
  end

  always_comb begin
    case (mode_i)
      4'd0, 4'd1: rd_exp = 3'd0;
      4'd6:       rd_exp = 3'd2;
      4'd2, 4'd3, 4'd4, 4'd5, 4'd7, 4'd8, 4'd9: rd_exp = 3'd1;
      default:    rd_exp = 3'd0;
    endcase
  end

  AST_IDLE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mem_re_o); // R1
  AST_READS_PER_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> rd_cnt == rd_exp); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_REGS_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_i) |-> done_o); // R9
  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && start_i |=> $stable(mode_i)); // R10
endmodule

bind opaddr_unit opaddr_chk #(.DW(DW), .NREG(NREG)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .done_o  (done_o),
  .mem_re_o(mem_re_o),
  .busy_i  (busy),
  .mode_i  (mode_q),
  .regs_i  (regs_o)
);

// File: tb/test_opaddr_unit.sv
module test_opaddr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [2:0]  rd = '0, rs = '0, rx = '0;
  logic [15:0] imm = '0;
  logic        mem_re;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic [255:0] regs;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mr [8];

  always #4 clk = ~clk;

  opaddr_unit i_opaddr_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .rd_i(rd), .rs_i(rs), .rx_i(rx), .imm_i(imm),
    .mem_re_o(mem_re), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .done_o(done), .regs_o(regs)
  );

  function automatic logic [31:0] memf(logic [31:0] a);
    return (a ^ 32'h3C5A_96E1) * 32'h0001_0003 + 32'h11;
  endfunction

  always @(posedge clk) if (mem_re) mem_rdata <= memf(mem_addr);

  task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic check_regs(string rq);
    int bad;
    bad = -1;
    for (int i = 0; i < 8; i++) if (regs[i*32 +: 32] !== mr[i] && bad < 0) bad = i;
    n_chk++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s reg %0d: actual %h expected %h", rq, bad, regs[bad*32 +: 32], mr[bad]);
    end
  endtask

  function automatic string tag_of(int m, int d, int s);
    if ((m == 7 || m == 8) && d == s) return "R8";
    case (m)
      0, 1:    return "R2";
      2, 3, 5: return "R3";
      4, 9:    return "R4";
      6:       return "R5";
      7:       return "R6";
      8:       return "R7";
      default: return "R11";
    endcase
  endfunction

  // reference model; returns expected read count
  function automatic int model(int m, int d, int s, int x, logic [15:0] k);
    logic [31:0] ke, b, ix, opnd, nb;
    int nr;
    ke = {{16{k[15]}}, k};
    b = mr[s]; ix = mr[x]; nb = b; nr = 1; opnd = '0;
    case (m)
      0: begin opnd = b;  nr = 0; end
      1: begin opnd = ke; nr = 0; end
      2: opnd = memf(b + ke);
      3: opnd = memf(b);
      4: opnd = memf(b + ix);
      5: opnd = memf(ke);
      6: begin opnd = memf(memf(b)); nr = 2; end
      7: begin opnd = memf(b); nb = b + 32'd4; end
      8: begin nb = b - 32'd4; opnd = memf(nb); end
      9: opnd = memf(ke + b + (ix << 2));
      default: nr = 0;
    endcase
    if (m <= 9) mr[d] = mr[d] + opnd;
    if (m == 7 || m == 8) mr[s] = nb;
    return nr;
  endfunction

  task automatic run_op(int m, int d, int s, int x, logic [15:0] k, bit inject);
    int exp_rd, nrd, cyc;
    string rq;
    rq = tag_of(m, d, s);
    exp_rd = model(m, d, s, x, k);
    @(negedge clk);
    start = 1'b1; mode = 4'(m); rd = 3'(d); rs = 3'(s); rx = 3'(x); imm = k;
    @(negedge clk);
    start = 1'b0;
    nrd = 0; cyc = 0;
    while (!done && cyc < 100) begin
      if (mem_re) nrd++;
      if (inject && cyc == 1) begin
        start = 1'b1; mode = 4'd1; rd = 3'd0; imm = 16'h7FFF;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check("R9", "done seen", 32'(done), 32'd1);
    check(rq, "read count", 32'(nrd), 32'(exp_rd));
    check_regs(rq);
    @(negedge clk);
    check("R9", "done single cycle", 32'(done), 32'd0);
    if (inject) begin
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (done) break;
      end
      check("R10", "no extra done", 32'(done), 32'd0);
      check_regs("R10");
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) mr[i] = '0;
    repeat (3) @(negedge clk);
    check_regs("R1");
    check("R1", "done in reset", 32'(done), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "no read idle", 32'(mem_re), 32'd0);
    check_regs("R1");

    run_op(1, 1, 0, 0, 16'h1000, 0);
    run_op(1, 2, 0, 0, 16'h0005, 0);
    run_op(1, 3, 0, 0, 16'hFFF8, 0);   // negative constant
    run_op(0, 4, 1, 0, 16'h0000, 0);
    run_op(2, 5, 1, 0, 16'hFFFC, 0);
    run_op(3, 6, 2, 0, 16'h0000, 0);
    run_op(4, 7, 1, 2, 16'h0000, 0);
    run_op(5, 0, 0, 0, 16'h8004, 0);
    run_op(6, 5, 1, 0, 16'h0000, 0);
    run_op(7, 4, 1, 0, 16'h0000, 0);
    run_op(8, 4, 2, 0, 16'h0000, 0);
    run_op(7, 1, 1, 0, 16'h0000, 0);
    run_op(8, 2, 2, 0, 16'h0000, 0);
    run_op(9, 6, 1, 1, 16'h0010, 0);
    run_op(9, 7, 3, 2, 16'hFFF0, 0);
    run_op(12, 3, 1, 2, 16'h1234, 0);
    run_op(15, 0, 0, 0, 16'hFFFF, 0);
    run_op(6, 6, 3, 0, 16'h0000, 1);
    run_op(0, 5, 5, 0, 16'h0000, 1);

    for (int n = 0; n < 400; n++) begin
      int m;
      m = int'($urandom % 16);
      if (m > 11) m = int'($urandom % 10);
      run_op(m, int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
             16'($urandom), ($urandom % 8) == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule